// File: doc/BRIEF.md
# Paged Hybrid Branch Target Generator

This block forms a branch target address from the current program counter and a 16-bit displacement without a full-width adder. The displacement is split in two. Its low 12 bits go into the target unchanged and select a location inside a 4 KB page. Its top 4 bits are a signed page step from -8 to +7, and only that step is added to the page number of the program counter. The carry chain is therefore 20 bits long instead of 32. The unchanged low bits are ready early, so fetch redirection or a target-buffer lookup can start from them. Relocatable code built for this scheme can move only in whole 4 KB pages.

The upstream stage presents a program counter and a displacement together with a one-cycle branch strobe. One clock later the block presents the registered target with a one-cycle valid pulse. It also presents a flag that reports when the page step wrapped past either end of the address space. There is no ready input and no back-pressure. A strobe is taken in every cycle it is high, and strobes in consecutive cycles give results in consecutive cycles. The consumer must take each result in the cycle its valid pulse is high. Between strobes the output register keeps the last result.

Top module: `brtgt_hybrid`

## Requirements
- R1: While reset is asserted and afterwards until the first strobe, `tgt_valid_o` is 0, `tgt_addr_o` is 0 and `tgt_wrap_o` is 0.
- R2: In the cycle after a strobe, bits 11:0 of `tgt_addr_o` equal bits 11:0 of the displacement sampled with the strobe.
- R3: In the cycle after a strobe, bits 31:12 of `tgt_addr_o` equal (pc[31:12] + D) mod 2^20. D is disp[15:12] read as a two's-complement value from -8 to +7.
- R4: Bits 11:0 of `pc_i` have no effect on `tgt_addr_o` or `tgt_wrap_o`.
- R5: In the cycle after a strobe, `tgt_wrap_o` is 1 exactly when pc[31:12] + D, taken as a signed integer, is below 0 or above 2^20-1.
- R6: `tgt_valid_o` is 1 in the cycle after each cycle in which `br_valid_i` is 1 and 0 in every other cycle. Strobes in consecutive cycles give valid pulses in consecutive cycles.
- R7: In a cycle after one in which `br_valid_i` is 0, `tgt_addr_o` and `tgt_wrap_o` keep their previous values, whatever `pc_i` and `disp_i` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | Branch strobe; `pc_i` and `disp_i` are sampled while it is high |
| pc_i | input | 32 | Program counter of the branch |
| disp_i | input | 16 | Displacement: [15:12] signed page step, [11:0] index within the page |
| tgt_valid_o | output | 1 | One-cycle pulse marking a new target |
| tgt_addr_o | output | 32 | Registered target address |
| tgt_wrap_o | output | 1 | Page step wrapped past the bottom or top of the address space |

## Verification
A wrong value in the output register appears on `tgt_addr_o` one cycle after the strobe. A wrong carry in the page adder is visible at once in the page bits or in the wrap flag. The largest risk is at the ends of the page range. There a carry or borrow that is wrongly dropped or kept changes the page by exactly 2^20 and flips the flag. The sweep therefore runs every page step against the lowest and highest pages, as well as pages in the middle of the range. A register that fails to hold shows up in the first idle cycle after a result, as a changed address or flag.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  localparam int unsigned DEF_PC_W   = 32;
  localparam int unsigned DEF_DISP_W = 16;
  localparam int unsigned DEF_IDX_W  = 12;
endpackage

// File: rtl/brtgt_page_adder.sv
module brtgt_page_adder #(
  parameter int unsigned PAGE_W = 20,
  parameter int unsigned OFS_W  = 4
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFS_W-1:0]  step_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              wrap_o
);
  localparam int unsigned EXT_W = PAGE_W + 1;

  logic [EXT_W-1:0] step_ext;
  logic [EXT_W-1:0] sum_ext;

  // The step is sign-extended one bit past the page width. The extra bit is
  // then set exactly when the signed sum leaves the range 0 .. 2^PAGE_W-1.
  always_comb begin
    step_ext = {{(EXT_W-OFS_W){step_i[OFS_W-1]}}, step_i};
    sum_ext  = {1'b0, page_i} + step_ext;
    page_o   = sum_ext[PAGE_W-1:0];
    wrap_o   = sum_ext[PAGE_W];
  end
endmodule

// File: rtl/brtgt_splice.sv
module brtgt_splice #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 12
) (
  input  logic [PC_W-IDX_W-1:0] page_i,
  input  logic [IDX_W-1:0]      idx_i,
  output logic [PC_W-1:0]       addr_o
);
  // The index bits pass through with no arithmetic.
  assign addr_o = {page_i, idx_i};
endmodule

// File: rtl/brtgt_hybrid.sv
module brtgt_hybrid #(
  parameter int unsigned PC_W   = brtgt_pkg::DEF_PC_W,
  parameter int unsigned DISP_W = brtgt_pkg::DEF_DISP_W,
  parameter int unsigned IDX_W  = brtgt_pkg::DEF_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              tgt_valid_o,
  output logic [PC_W-1:0]   tgt_addr_o,
  output logic              tgt_wrap_o
);
  localparam int unsigned PAGE_W = PC_W - IDX_W;
  localparam int unsigned OFS_W  = DISP_W - IDX_W;
  localparam logic [PAGE_W-1:0] PAGE_MAX = '1;
  localparam logic [PAGE_W-1:0] POS_SPAN = PAGE_W'(2**(OFS_W-1) - 1);
  localparam logic [PAGE_W-1:0] NEG_SPAN = PAGE_W'(2**(OFS_W-1));

  logic [PAGE_W-1:0] cur_page;
  logic [OFS_W-1:0]  step;
  logic [PAGE_W-1:0] nxt_page;
  logic              nxt_wrap;
  logic [PC_W-1:0]   nxt_addr;

  assign cur_page = pc_i[PC_W-1:IDX_W];
  assign step     = disp_i[DISP_W-1:IDX_W];

  brtgt_page_adder #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) i_adder (
    .page_i (cur_page),
    .step_i (step),
    .page_o (nxt_page),
    .wrap_o (nxt_wrap)
  );

  brtgt_splice #(.PC_W(PC_W), .IDX_W(IDX_W)) i_splice (
    .page_i (nxt_page),
    .idx_i  (disp_i[IDX_W-1:0]),
    .addr_o (nxt_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_valid_o <= 1'b0;
      tgt_addr_o  <= '0;
      tgt_wrap_o  <= 1'b0;
    end else begin
      tgt_valid_o <= br_valid_i;
      if (br_valid_i) begin
        tgt_addr_o <= nxt_addr;
        tgt_wrap_o <= nxt_wrap;
      end
    end
  end

  // Cases where the wrap flag can be predicted from the inputs alone.
  logic safe_step;
  logic top_cross;
  assign safe_step = (!step[OFS_W-1] && cur_page <= PAGE_MAX - POS_SPAN) ||
                     ( step[OFS_W-1] && cur_page >= NEG_SPAN);
  assign top_cross = !step[OFS_W-1] && (step != '0) && (cur_page == PAGE_MAX);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid_i |=> tgt_valid_o); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid_i |=> !tgt_valid_o); // R6
  AST_INDEX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid_i |=> tgt_addr_o[IDX_W-1:0] == $past(disp_i[IDX_W-1:0])); // R2
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid_i |=> tgt_addr_o[PC_W-1:IDX_W] ==
      PAGE_W'($past(pc_i[PC_W-1:IDX_W]) +
              {{(PAGE_W-OFS_W){$past(disp_i[DISP_W-1])}}, $past(disp_i[DISP_W-1:IDX_W])})); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid_i && safe_step |=> !tgt_wrap_o); // R5
  AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid_i && top_cross |=> tgt_wrap_o); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid_i |=> $stable(tgt_addr_o) && $stable(tgt_wrap_o)); // R7
endmodule

// File: tb/test_brtgt_hybrid.sv
module test_brtgt_hybrid;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W   = 32;
  localparam int DISP_W = 16;
  localparam int IDX_W  = 12;
  localparam int PAGE_W = PC_W - IDX_W;
  localparam int NPAGES = 1 << PAGE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              br_valid_i = 1'b0;
  logic [PC_W-1:0]   pc_i = '0;
  logic [DISP_W-1:0] disp_i = '0;
  logic              tgt_valid_o;
  logic [PC_W-1:0]   tgt_addr_o;
  logic              tgt_wrap_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1bad_c0de;

  brtgt_hybrid i_brtgt_hybrid (
    .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid_i), .pc_i(pc_i),
    .disp_i(disp_i), .tgt_valid_o(tgt_valid_o), .tgt_addr_o(tgt_addr_o),
    .tgt_wrap_o(tgt_wrap_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] next_rand(logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13;
    x ^= x >> 17;
    x ^= x << 5;
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one strobe at a falling edge and checks the result at the next falling edge.
  task automatic branch(input int page, input int step, input logic [IDX_W-1:0] idx,
                        input logic [IDX_W-1:0] pc_low);
    int sum;
    logic [PC_W-1:0] exp_addr;
    bit exp_wrap;
    br_valid_i = 1'b1;
    pc_i   = {PAGE_W'(page), pc_low};
    disp_i = {4'(step), idx};
    sum = page + step;
    exp_wrap = (sum < 0) || (sum >= NPAGES);
    exp_addr = {PAGE_W'(sum), idx};
    @(negedge clk);
    check(tgt_valid_o == 1'b1, "R6", 64'(tgt_valid_o), 64'd1);
    check(tgt_addr_o[IDX_W-1:0] == idx, "R2", 64'(tgt_addr_o[IDX_W-1:0]), 64'(idx));
    check(tgt_addr_o[PC_W-1:IDX_W] == exp_addr[PC_W-1:IDX_W], "R3",
          64'(tgt_addr_o[PC_W-1:IDX_W]), 64'(exp_addr[PC_W-1:IDX_W]));
    check(tgt_wrap_o == exp_wrap, "R5", 64'(tgt_wrap_o), 64'(exp_wrap));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [PC_W-1:0] held_addr;
    logic held_wrap;
    repeat (3) @(negedge clk);
    // R1: outputs are cleared while reset is held
    check(tgt_valid_o == 1'b0 && tgt_addr_o == '0 && tgt_wrap_o == 1'b0, "R1",
          64'(tgt_addr_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tgt_valid_o == 1'b0 && tgt_addr_o == '0 && tgt_wrap_o == 1'b0, "R1",
          64'({tgt_valid_o, tgt_wrap_o}), 64'd0);

    // R2 R3 R5 R6: every page step against the lowest, highest and middle pages,
    // with strobes in back-to-back cycles
    for (int b = 0; b < 30; b++) begin
      int page;
      if (b < 10) page = b;
      else if (b < 20) page = NPAGES - 20 + b;
      else page = (NPAGES / 2) - 5 + (b - 20);
      for (int s = -8; s < 8; s++) begin
        logic [IDX_W-1:0] idx;
        seed = next_rand(seed);
        idx = (s == -8) ? '0 : (s == 7) ? '1 : seed[IDX_W-1:0];
        branch(page, s, idx, seed[31:20]);
      end
    end

    // R4: the low pc bits are varied while page and displacement stay fixed
    for (int k = 0; k < 8; k++) begin
      logic [PC_W-1:0] first_addr;
      logic first_wrap;
      seed = next_rand(seed);
      branch(NPAGES - 1, 3, 12'h5a5, 12'h000);
      first_addr = tgt_addr_o;
      first_wrap = tgt_wrap_o;
      branch(NPAGES - 1, 3, 12'h5a5, seed[IDX_W-1:0]);
      check(tgt_addr_o == first_addr && tgt_wrap_o == first_wrap, "R4",
            64'(tgt_addr_o), 64'(first_addr));
    end

    // R6 R7: after a single strobe the valid drops and the outputs hold
    branch(12345, -3, 12'h0f0, 12'hfff);
    branch(NPAGES - 2, 5, 12'habc, 12'h001);
    held_addr = tgt_addr_o;
    held_wrap = tgt_wrap_o;
    br_valid_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      seed = next_rand(seed);
      pc_i = seed;
      disp_i = seed[15:0];
      @(negedge clk);
      check(tgt_valid_o == 1'b0, "R6", 64'(tgt_valid_o), 64'd0);
      check(tgt_addr_o == held_addr && tgt_wrap_o == held_wrap, "R7",
            64'(tgt_addr_o), 64'(held_addr));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule